// File: doc/BRIEF.md
# Content-Aware 4x4 Inverse Quantizer and Transform

The block accepts one 4x4 block of quantized residual coefficients, a dequantization scale and a mode in a single handshake beat. It returns sixteen signed results in one output beat. Before any arithmetic starts, the block sorts the incoming block into one of three classes. An all-zero block produces zeros at once. A block whose only non-zero value is the DC coefficient takes a one-multiply shortcut. Every other block goes through the full path: it is dequantized one coefficient per cycle on a single multiplier, then passed through a multiplication-free row transform, a transpose, and a column transform.

One butterfly engine serves three kinds of block. Mode 0 is the luma 4x4 residual: the butterfly halves its odd inputs and the result is rounded down by 64. Mode 1 is the luma 4x4 DC Hadamard: no halving and no rounding. Mode 2 is the chroma 2x2 DC: only the top-left 2x2 corner is used. Mode 3 behaves like mode 0. The block is meant to sit between a coefficient parser and a reconstruction stage. It starts a new block as soon as the previous result has been handed out.

Top module: `iqt4x4_engine`

## Requirements
- R1: `in_ready_o` is 1 exactly when the engine is idle, including during and straight after reset. A block is taken on a clock edge where `in_valid_i` and `in_ready_o` are both 1. `out_valid_o` is a one-cycle pulse, and `in_ready_o` is 1 in the cycle after it. `res_o` is meaningful only while `out_valid_o` is 1.
- R2: A block with all (mode-masked) coefficients zero raises `out_valid_o` in the cycle right after the accepting edge, with all sixteen results zero.
- R3: A block whose only non-zero (mode-masked) coefficient is index 0 raises `out_valid_o` one cycle later than R2. Let d = coef0*scale. Mode 0 and mode 3 give (d+32)>>6, arithmetic shift, on all sixteen outputs. Mode 1 gives d on all sixteen outputs. Mode 2 gives d at indices 0, 1, 4 and 5, and 0 elsewhere.
- R4: Any other block raises `out_valid_o` in the cycle after the 24th clock edge that follows the accepting edge.
- R5: In mode 0 and mode 3, m = coef*scale is computed per coefficient. Each row (a,b,c,d) = (m[4r..4r+3]) becomes (a+c+b+(d>>1), a-c+(b>>1)-d, a-c-(b>>1)+d, a+c-b-(d>>1)). The same step is then applied to each column of the row results, and every output is (x+32)>>6. All shifts are arithmetic.
- R6: In mode 1, rows and then columns become (a+b+c+d, a+b-c-d, a-b-c+d, a-b+c-d) of m, with no rounding.
- R7: In mode 2, with p=m0, q=m1, s=m4, t=m5, the outputs are: index 0 = p+q+s+t, index 1 = p-q+s-t, index 4 = p+q-s-t, index 5 = p-q-s+t. All other outputs are 0.
- R8: In mode 2, coefficients outside indices 0, 1, 4 and 5 are ignored, and this includes classification. A block that is non-zero only outside the corner takes the R2 path. Such a block with a non-zero DC takes the R3 path.
- R9: Coefficient i = 4*row+col is the signed CW-bit field `coef_i[i*CW +: CW]`. Result i is the signed field `res_o[i*OW +: OW]`, with OW = CW+SW+5. `scale_i` is unsigned.
- R10: While the engine is busy, changes on `in_valid_i`, `coef_i`, `scale_i` and `mode_i` do not affect the result being computed, and they are not taken as a new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Block offered |
| in_ready_o | output | 1 | Engine idle, block will be taken |
| mode_i | input | 2 | 0 luma residual, 1 luma DC Hadamard, 2 chroma 2x2 DC, 3 as 0 |
| scale_i | input | SW (8) | Unsigned dequantization scale |
| coef_i | input | 16*CW (256) | Sixteen signed coefficients, raster order |
| out_valid_o | output | 1 | One-cycle result pulse |
| res_o | output | 16*OW (464) | Sixteen signed results, raster order |

## Verification
The bench goes after the class boundaries first. It sends all-zero blocks, DC-only blocks with positive and negative DC, and blocks with a single AC value. A classifier that lumped these classes together would either deliver the right values at the wrong cycle or skip the transform that a lone AC value needs. Negative sums check rounding: a logical shift or a round toward zero shows up as results that are off by one, or as huge positive results. Chroma blocks with energy only outside the corner, and extreme coefficient and scale values in Hadamard mode, expose a missing mask or too little headroom. Garbage driven while the engine is busy, together with distinct per-index values, exposes a register that reloads while busy and any swapped row, column or field order.

// File: rtl/iqt_pkg.sv
package iqt_pkg;
  localparam logic [1:0] MODE_RES = 2'd0;
  localparam logic [1:0] MODE_HAD = 2'd1;
  localparam logic [1:0] MODE_CDC = 2'd2;

  typedef enum logic [1:0] {CLS_ZERO, CLS_DC, CLS_FULL} iqt_cls_e;
  typedef enum logic [2:0] {ST_IDLE, ST_DQ, ST_ROW, ST_COL, ST_OUT} iqt_state_e;
endpackage

// File: rtl/iqt_classify.sv
module iqt_classify
  import iqt_pkg::*;
#(
  parameter int DIM = 4,
  parameter int CW  = 16,
  localparam int NC = DIM * DIM
) (
  input  logic [NC*CW-1:0] coef_i,
  input  logic             chroma_i,
  output logic [NC*CW-1:0] coef_o,
  output iqt_cls_e         cls_o
);
  logic [NC-1:0] nz;

  for (genvar g = 0; g < NC; g++) begin : g_lane
    localparam bit KEEP = ((g / DIM) < 2) && ((g % DIM) < 2);
    logic [CW-1:0] v;
    assign v = (chroma_i && !KEEP) ? '0 : coef_i[g*CW +: CW];
    assign coef_o[g*CW +: CW] = v;
    assign nz[g] = |v;
  end

  always_comb begin
    if (nz == '0)              cls_o = CLS_ZERO;
    else if (nz[NC-1:1] == '0) cls_o = CLS_DC;
    else                       cls_o = CLS_FULL;
  end
endmodule

// File: rtl/iqt_dq_mult.sv
module iqt_dq_mult #(
  parameter int CW = 16,
  parameter int SW = 8,
  localparam int DW = CW + SW + 1
) (
  input  logic [CW-1:0]        coef_i,
  input  logic [SW-1:0]        scale_i,
  output logic signed [DW-1:0] prod_o
);
  // scale is unsigned: widen by a zero bit, product fits DW exactly
  assign prod_o = $signed(coef_i) * $signed({1'b0, scale_i});
endmodule

// File: rtl/iqt_core_1d.sv
module iqt_core_1d #(
  parameter int IW = 29
) (
  input  logic signed [IW-1:0] a_i,
  input  logic signed [IW-1:0] b_i,
  input  logic signed [IW-1:0] c_i,
  input  logic signed [IW-1:0] d_i,
  input  logic                 half_i,
  output logic signed [IW-1:0] y0_o,
  output logic signed [IW-1:0] y1_o,
  output logic signed [IW-1:0] y2_o,
  output logic signed [IW-1:0] y3_o
);
  logic signed [IW-1:0] bh, dh, e0, e1, e2, e3;

  assign bh = half_i ? (b_i >>> 1) : b_i;
  assign dh = half_i ? (d_i >>> 1) : d_i;
  assign e0 = a_i + c_i;
  assign e1 = a_i - c_i;
  assign e2 = bh - d_i;
  assign e3 = b_i + dh;
  assign y0_o = e0 + e3;
  assign y1_o = e1 + e2;
  assign y2_o = e1 - e2;
  assign y3_o = e0 - e3;
endmodule

// File: rtl/iqt4x4_engine.sv
module iqt4x4_engine
  import iqt_pkg::*;
#(
  parameter int CW = 16,
  parameter int SW = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         in_valid_i,
  output logic                         in_ready_o,
  input  logic [1:0]                   mode_i,
  input  logic [SW-1:0]                scale_i,
  input  logic [16*CW-1:0]             coef_i,
  output logic                         out_valid_o,
  output logic [16*(CW+SW+5)-1:0]      res_o
);
  localparam int DIM      = 4;
  localparam int NC       = DIM * DIM;
  localparam int DW       = CW + SW + 1;
  localparam int IW       = DW + 4;
  localparam int OW       = IW;
  localparam int CNTW     = $clog2(NC);
  localparam int PW       = $clog2(DIM);
  localparam int RND_SH   = 6;
  localparam int FULL_LAT = NC + 2 * DIM;

  function automatic bit in_corner(input int i);
    return ((i / DIM) < 2) && ((i % DIM) < 2);
  endfunction

  function automatic logic signed [IW-1:0] rnd(input logic signed [IW-1:0] x);
    logic signed [IW-1:0] t;
    t = x + $signed(IW'(1 << (RND_SH - 1)));
    return t >>> RND_SH;
  endfunction

  iqt_state_e           state_q;
  iqt_cls_e             cls_q, cls_in;
  logic [1:0]           mode_q;
  logic [SW-1:0]        scale_q;
  logic [CW-1:0]        cf_q  [NC];
  logic signed [IW-1:0] buf_q [NC];
  logic signed [OW-1:0] res_q [NC];
  logic [CNTW-1:0]      cnt_q;
  logic [PW-1:0]        rc;

  logic [NC*CW-1:0]     coef_m;
  logic                 chroma_q, half_q;
  logic signed [DW-1:0] prod;
  logic signed [IW-1:0] prod_x;
  logic signed [IW-1:0] ln  [DIM];
  logic signed [IW-1:0] yv  [DIM];
  logic signed [IW-1:0] ym  [DIM];
  logic signed [IW-1:0] fin [DIM];
  logic signed [IW-1:0] ca, cb, cc, cd;
  logic                 accept;

  assign accept     = in_valid_i && (state_q == ST_IDLE);
  assign in_ready_o = (state_q == ST_IDLE);
  assign out_valid_o = (state_q == ST_OUT);
  assign chroma_q   = (mode_q == MODE_CDC);
  assign half_q     = !((mode_q == MODE_HAD) || (mode_q == MODE_CDC));
  assign rc         = cnt_q[PW-1:0];

  iqt_classify #(.DIM(DIM), .CW(CW)) u_cls (
    .coef_i  (coef_i),
    .chroma_i(mode_i == MODE_CDC),
    .coef_o  (coef_m),
    .cls_o   (cls_in)
  );

  iqt_dq_mult #(.CW(CW), .SW(SW)) u_mul (
    .coef_i (cf_q[cnt_q]),
    .scale_i(scale_q),
    .prod_o (prod)
  );

  assign prod_x = {{(IW-DW){prod[DW-1]}}, prod};

  // lane fetch: rows in ROW pass, columns (transposed) in COL pass
  always_comb begin
    for (int k = 0; k < DIM; k++) begin
      if (state_q == ST_COL) ln[k] = buf_q[k*DIM + int'(rc)];
      else                   ln[k] = buf_q[int'(rc)*DIM + k];
    end
    ca = ln[0];
    if (chroma_q) begin
      cb = '0; cc = ln[1]; cd = '0;
    end else begin
      cb = ln[1]; cc = ln[2]; cd = ln[3];
    end
  end

  iqt_core_1d #(.IW(IW)) u_core (
    .a_i(ca), .b_i(cb), .c_i(cc), .d_i(cd),
    .half_i(half_q),
    .y0_o(yv[0]), .y1_o(yv[1]), .y2_o(yv[2]), .y3_o(yv[3])
  );

  always_comb begin
    for (int k = 0; k < DIM; k++) begin
      ym[k]  = (chroma_q && k >= 2) ? '0 : yv[k];
      fin[k] = half_q ? rnd(ym[k]) : ym[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cls_q   <= CLS_ZERO;
      mode_q  <= '0;
      scale_q <= '0;
      cnt_q   <= '0;
      for (int i = 0; i < NC; i++) begin
        cf_q[i]  <= '0;
        buf_q[i] <= '0;
        res_q[i] <= '0;
      end
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          for (int i = 0; i < NC; i++) cf_q[i] <= coef_m[i*CW +: CW];
          scale_q <= scale_i;
          mode_q  <= mode_i;
          cls_q   <= cls_in;
          cnt_q   <= '0;
          if (cls_in == CLS_ZERO) begin
            for (int i = 0; i < NC; i++) res_q[i] <= '0;
            state_q <= ST_OUT;
          end else begin
            state_q <= ST_DQ;
          end
        end
        ST_DQ: begin
          if (cls_q == CLS_DC) begin
            for (int i = 0; i < NC; i++) begin
              if (chroma_q && !in_corner(i)) res_q[i] <= '0;
              else                           res_q[i] <= half_q ? rnd(prod_x) : prod_x;
            end
            state_q <= ST_OUT;
          end else begin
            buf_q[cnt_q] <= prod_x;
            if (cnt_q == CNTW'(NC - 1)) begin
              cnt_q   <= '0;
              state_q <= ST_ROW;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_ROW: begin
          for (int k = 0; k < DIM; k++) buf_q[int'(rc)*DIM + k] <= ym[k];
          if (rc == PW'(DIM - 1)) begin
            cnt_q   <= '0;
            state_q <= ST_COL;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_COL: begin
          for (int k = 0; k < DIM; k++) res_q[k*DIM + int'(rc)] <= fin[k];
          if (rc == PW'(DIM - 1)) begin
            cnt_q   <= '0;
            state_q <= ST_OUT;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_OUT:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NC; g++) begin : g_out
    assign res_o[g*OW +: OW] = res_q[g];
  end

  // ---------------- assertions ----------------
  logic [5:0] lat_cnt;
  logic       outside_nz;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               lat_cnt <= '0;
    else if (accept)           lat_cnt <= '0;
    else if (lat_cnt != 6'h3f) lat_cnt <= lat_cnt + 1'b1;
  end

  always_comb begin
    outside_nz = 1'b0;
    for (int i = 0; i < NC; i++)
      if (!in_corner(i) && res_q[i] != '0) outside_nz = 1'b1;
  end

  assert_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o && in_ready_o);

  assert_zero_fast_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && cls_in == CLS_ZERO |=> out_valid_o && (res_o == '0));

  assert_dc_short_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && cls_in == CLS_DC |=> !out_valid_o ##1 out_valid_o);

  assert_full_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && cls_q == CLS_FULL |-> lat_cnt == 6'(FULL_LAT));

  assert_chroma_corner_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && chroma_q |-> !outside_nz);

  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> $stable(mode_q) && $stable(scale_q));
endmodule

// File: tb/test_iqt4x4_engine.sv
`timescale 1ns/1ps
module test_iqt4x4_engine;
  localparam int CW = 16;
  localparam int SW = 8;
  localparam int OW = CW + SW + 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tb_valid = 1'b0;
  logic [1:0]      tb_mode = '0;
  logic [SW-1:0]   tb_scale = '0;
  logic [16*CW-1:0] tb_coef = '0;
  logic            in_ready, out_valid;
  logic [16*OW-1:0] res;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int seed = 7;

  always #2 clk = ~clk;

  iqt4x4_engine #(.CW(CW), .SW(SW)) i_iqt4x4_engine (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(tb_valid), .in_ready_o(in_ready),
    .mode_i(tb_mode), .scale_i(tb_scale), .coef_i(tb_coef),
    .out_valid_o(out_valid), .res_o(res)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int rnext();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 32767;
  endfunction

  // ---------------- behavioural reference ----------------
  bit     m_idle = 1'b1, m_pend = 1'b0, m_valid = 1'b0, m_acc = 1'b0;
  int     m_rem = 0;
  longint m_exp [16];
  string  m_tag = "R1";
  string  drv_tag = "R1";
  bit     run_chk = 1'b0;

  function automatic longint tx(input int k, input longint a, input longint b,
                                input longint c, input longint d, input bit had);
    if (had) begin
      case (k)
        0: return a + b + c + d;
        1: return a + b - c - d;
        2: return a - b - c + d;
        default: return a - b + c - d;
      endcase
    end
    case (k)
      0: return a + b + c + (d >>> 1);
      1: return a + (b >>> 1) - c - d;
      2: return a - (b >>> 1) - c + d;
      default: return a - b + c - (d >>> 1);
    endcase
  endfunction

  task automatic ref_calc(output int lat);
    longint m [16];
    longint t [16];
    int nz, nzac;
    bit corner;
    logic signed [CW-1:0] v;
    nz = 0; nzac = 0;
    for (int i = 0; i < 16; i++) begin
      v = tb_coef[i*CW +: CW];
      corner = (i == 0) || (i == 1) || (i == 4) || (i == 5);
      m[i] = (tb_mode == 2 && !corner) ? 0 : longint'(v) * longint'(tb_scale);
      if (m[i] != 0 || (tb_mode == 2 && corner && v != 0)) begin
        nz++;
        if (i != 0) nzac++;
      end
    end
    if (nz == 0) begin
      lat = 0;
      for (int i = 0; i < 16; i++) m_exp[i] = 0;
    end else if (nzac == 0) begin
      lat = 1;
      for (int i = 0; i < 16; i++) begin
        corner = (i == 0) || (i == 1) || (i == 4) || (i == 5);
        if (tb_mode == 1)      m_exp[i] = m[0];
        else if (tb_mode == 2) m_exp[i] = corner ? m[0] : 0;
        else                   m_exp[i] = (m[0] + 32) >>> 6;
      end
    end else begin
      lat = 24;
      if (tb_mode == 2) begin
        for (int i = 0; i < 16; i++) m_exp[i] = 0;
        m_exp[0] = m[0] + m[1] + m[4] + m[5];
        m_exp[1] = m[0] - m[1] + m[4] - m[5];
        m_exp[4] = m[0] + m[1] - m[4] - m[5];
        m_exp[5] = m[0] - m[1] - m[4] + m[5];
      end else begin
        for (int r = 0; r < 4; r++)
          for (int k = 0; k < 4; k++)
            t[r*4+k] = tx(k, m[r*4], m[r*4+1], m[r*4+2], m[r*4+3], tb_mode == 1);
        for (int c = 0; c < 4; c++)
          for (int k = 0; k < 4; k++) begin
            m_exp[k*4+c] = tx(k, t[c], t[4+c], t[8+c], t[12+c], tb_mode == 1);
            if (tb_mode != 1) m_exp[k*4+c] = (m_exp[k*4+c] + 32) >>> 6;
          end
      end
    end
  endtask

  always @(posedge clk) begin
    int lat;
    bit acc;
    cyc++;
    if (!rst_n) begin
      m_idle = 1'b1; m_pend = 1'b0; m_valid = 1'b0; m_acc = 1'b0; m_rem = 0;
    end else begin
      acc = tb_valid && m_idle;
      if (m_pend && m_rem == 0) begin
        m_pend = 1'b0; m_idle = 1'b1;
      end else if (m_pend) begin
        m_rem--;
      end
      if (acc) begin
        ref_calc(lat);
        m_pend = 1'b1; m_idle = 1'b0; m_rem = lat; m_tag = drv_tag;
      end
      m_acc = acc;
      m_valid = m_pend && m_rem == 0;
    end
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // compared on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      chk("R1 ready", longint'(in_ready), longint'(m_idle));
      chk({m_tag, " valid timing"}, longint'(out_valid), longint'(m_valid));
      if (m_valid && out_valid)
        for (int i = 0; i < 16; i++) begin
          logic signed [OW-1:0] sl;
          sl = res[i*OW +: OW];
          chk({m_tag, " value"}, longint'(sl), m_exp[i]);
        end
    end
  end

  // ---------------- stimulus ----------------
  task automatic clr();
    tb_coef = '0;
  endtask

  task automatic setc(input int i, input int v);
    tb_coef[i*CW +: CW] = CW'(v);
  endtask

  task automatic send(input string tag, input int md, input int sc, input bit noise);
    drv_tag  = tag;
    tb_mode  = 2'(md);
    tb_scale = SW'(sc);
    tb_valid = 1'b1;
    do @(negedge clk); while (!m_acc);
    if (noise) begin
      for (int i = 0; i < 16; i++) setc(i, rnext() - 16384);
      tb_mode  = 2'(rnext());
      tb_scale = SW'(rnext());
      while (!m_valid) @(negedge clk);
    end
    tb_valid = 1'b0;
    while (!m_idle) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ready", longint'(in_ready), 1);
    chk("R1 reset valid", longint'(out_valid), 0);
    rst_n = 1'b1;
    run_chk = 1'b1;
    @(negedge clk);

    clr(); send("R2", 0, 20, 0);
    clr(); send("R2", 1, 255, 0);
    clr(); setc(0, 100);  send("R3", 0, 13, 0);
    clr(); setc(0, -77);  send("R3", 0, 9, 0);
    clr(); setc(0, -300); send("R3", 1, 7, 0);
    clr(); setc(0, 55);   send("R3", 2, 3, 0);
    clr(); setc(7, 1);    send("R5", 0, 16, 0);
    clr(); setc(15, -5);  send("R5", 0, 40, 0);
    for (int n = 0; n < 6; n++) begin
      clr();
      for (int i = 0; i < 16; i++) setc(i, (rnext() % 128) - 64);
      send("R5", 0, rnext() % 256, 0);
    end
    clr(); for (int i = 0; i < 16; i++) setc(i, (rnext() % 512) - 256);
    send("R5", 3, 77, 0);
    for (int n = 0; n < 4; n++) begin
      clr();
      for (int i = 0; i < 16; i++) setc(i, rnext() - 16384);
      send("R6", 1, rnext() % 256, 0);
    end
    clr(); for (int i = 0; i < 16; i++) setc(i, -32768);
    send("R6", 1, 255, 0);
    clr(); for (int i = 0; i < 16; i++) setc(i, (i % 2) ? 32767 : -32768);
    send("R5", 0, 255, 0);
    clr(); setc(0, 11); setc(1, -4); setc(4, 9); setc(5, 2);
    send("R7", 2, 5, 0);
    clr(); for (int i = 0; i < 16; i++) setc(i, (rnext() % 2000) - 1000);
    send("R7", 2, 200, 0);
    clr(); for (int i = 0; i < 16; i++) if (i != 0 && i != 1 && i != 4 && i != 5) setc(i, 99);
    send("R8", 2, 10, 0);
    setc(0, -21); send("R8", 2, 10, 0);
    clr(); for (int i = 0; i < 16; i++) setc(i, i * 3 - 20);
    send("R9", 1, 1, 0);
    clr(); for (int i = 0; i < 16; i++) setc(i, 16 * i + 1);
    send("R9", 0, 64, 0);
    clr(); for (int i = 0; i < 16; i++) setc(i, (rnext() % 100) - 50);
    send("R10", 0, 33, 1);
    clr(); setc(0, 8); send("R10", 1, 2, 1);
    clr(); send("R10", 0, 5, 1);
    clr(); setc(3, 12); send("R4", 0, 21, 0);
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule